// File: doc/BRIEF.md
# Block Clock-Line Generator

This block derives three clock lines for one logic block of a programmable fabric. It chooses among four global clocks and four product-term signals, and a static configuration word sets the options. It does not gate or forward real clocks. Each line is modelled in a synchronous way on a fast system clock `clk`. The selected source is sampled, and the block reports the line's current level together with a one-cycle qualified event pulse. The pulse marks an active edge that falls while the line's enable is true. Registers downstream can therefore be modelled and verified on a single clock.

Line 0 follows a chosen global clock and is always qualified by an enable taken from a chosen product term. It fires on rising edges, on falling edges, or on both edges. Line 1 follows a chosen global clock and fires on its rising edges. It can optionally be qualified by a product-term enable. Line 2 is by default the inverse of line 1 and shares line 1's enable. When line 1 uses no enable, line 2 can instead follow a chosen product term as its clock. If both line 1's enable and line 2's product-term clock are requested, that combination is rejected: line 2 falls back to the inverse of line 1 and an error flag is raised. The configuration word is captured only while reset is asserted.

Top module: `blkclk_gen`

## Requirements
- R1: `cfg_word` is captured on every `clk` edge while the block is held in reset. A change to `cfg_word` after reset has been released has no effect on any output.
- R2: While `rst_n` is low, `line_clk`, `line_evt` and `cfg_err` are all zero.
- R3: Configuration bits [1:0] select the line 0 global clock and bits [5:4] select the product term used as line 0's enable. With mode bits [3:2] = 0, line 0 pulses once for each rising edge of its source while its enable is high.
- R4: With mode bits [3:2] = 1, line 0 pulses once for each falling edge of its source while its enable is high, and not on rising edges.
- R5: With mode bits [3:2] = 2 (dual edge), line 0 pulses once for each rising edge and once for each falling edge of its source while its enable is high.
- R6: In every line 0 mode, no edge of the source produces a line 0 pulse while the selected enable product term is low.
- R7: Bits [7:6] select the line 1 global clock. Line 1 pulses on each rising edge of that clock. When bit 8 is 1, line 1 pulses only while the product term selected by bits [10:9] is high. When bit 8 is 0, it pulses on every rising edge.
- R8: When line 2 is not in product-term mode, its level is the inverse of line 1's level. It pulses on each falling edge of the line 1 clock, qualified by the same enable as line 1.
- R9: When bit 11 is 1 and bit 8 is 0, line 2 follows the product term selected by bits [13:12] and pulses on each of its rising edges without any enable. Global clock edges then produce no line 2 pulses.
- R10: When bits 11 and 8 are both 1, `cfg_err` is 1 after reset release, and line 2 behaves as described in R8.
- R11: Mode value 3 in bits [3:2] is reserved. It raises `cfg_err`, and line 0 then behaves as in rising-edge mode.
- R12: A source change set up before `clk` edge k updates `line_clk` after edge k. The matching `line_evt` pulse is high for exactly the one cycle after edge k+1.
- R13: Edges on global clocks that are not selected for a line produce no pulses on that line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample every source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| gclk | input | 4 | Global clock levels, sampled as data |
| pterm | input | 4 | Product-term signals used as enables or as a clock |
| cfg_word | input | 14 | Static configuration, captured during reset |
| line_clk | output | 3 | Sampled level of each clock line |
| line_evt | output | 3 | One-cycle qualified active-edge pulse for each line |
| cfg_err | output | 1 | Set when the captured configuration is illegal or reserved |

## Verification
The hardest situation to reach is the illegal mix of a line 1 enable with a line 2 product-term clock, because the block must quietly redirect line 2 while it keeps running. The bench brings this about with a reset that loads exactly that word. It then toggles both the product term that would have been the clock and the line 1 global clock. Pulses are expected only from the global clock's falling edges, and `cfg_err` is expected high. A second hard case is a configuration change made while the block runs. The bench writes a dual-edge word after release and shows that the pulse count still matches rising-only behaviour.

// File: rtl/blkclk_pkg.sv
package blkclk_pkg;

  localparam int GCLK_N  = 4;
  localparam int PT_N    = 4;
  localparam int LINES   = 3;
  localparam int GSEL_W  = $clog2(GCLK_N);
  localparam int PSEL_W  = $clog2(PT_N);

  // Line 0 edge qualifier selection
  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_RSVD = 2'd3
  } edge_mode_e;

  // Packed so that l1_src occupies the lowest bits of the word
  typedef struct packed {
    logic [PSEL_W-1:0] l3_pt_sel;
    logic              l3_pt;
    logic [PSEL_W-1:0] l2_en_sel;
    logic              l2_en_use;
    logic [GSEL_W-1:0] l2_src;
    logic [PSEL_W-1:0] l1_en_sel;
    edge_mode_e        l1_mode;
    logic [GSEL_W-1:0] l1_src;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/blkclk_rst_sync.sv
module blkclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign run = sh_q[STAGES-1];

endmodule

// File: rtl/blkclk_cfg_hold.sv
module blkclk_cfg_hold
  import blkclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CFG_W-1:0] cfg_in,
  output cfg_t             cfg_q,
  output logic             l3_use_pt,
  output logic             cfg_err
);

  logic illegal_mix;
  logic rsvd_mode;
  logic err_d;
  logic err_q;
  logic cfg_load;

  // capture only while the synchronised reset holds the block idle
  assign cfg_load = ~run;

  always_ff @(posedge clk) begin
    if (cfg_load) cfg_q <= cfg_t'(cfg_in);
  end

  always_comb begin
    illegal_mix = cfg_q.l2_en_use & cfg_q.l3_pt;
    rsvd_mode   = (cfg_q.l1_mode == EDGE_RSVD);
    l3_use_pt   = cfg_q.l3_pt & ~cfg_q.l2_en_use;
    err_d       = run ? (illegal_mix | rsvd_mode) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign cfg_err = err_q;

endmodule

// File: rtl/blkclk_src_sel.sv
module blkclk_src_sel
  import blkclk_pkg::*;
(
  input  cfg_t              cfg_q,
  input  logic              l3_use_pt,
  input  logic [GCLK_N-1:0] gclk,
  input  logic [PT_N-1:0]   pterm,
  output logic [LINES-1:0]  lvl,
  output logic [LINES-1:0]  en,
  output logic [LINES-1:0]  rise_en,
  output logic [LINES-1:0]  fall_en
);

  logic l2_lvl;
  logic l2_en;

  always_comb begin
    // line 0: global clock, always enabled through a product term
    lvl[0]     = gclk[cfg_q.l1_src];
    en[0]      = pterm[cfg_q.l1_en_sel];
    rise_en[0] = (cfg_q.l1_mode != EDGE_FALL);
    fall_en[0] = (cfg_q.l1_mode == EDGE_FALL) | (cfg_q.l1_mode == EDGE_BOTH);

    // line 1: global clock, optional enable
    l2_lvl     = gclk[cfg_q.l2_src];
    l2_en      = cfg_q.l2_en_use ? pterm[cfg_q.l2_en_sel] : 1'b1;
    lvl[1]     = l2_lvl;
    en[1]      = l2_en;
    rise_en[1] = 1'b1;
    fall_en[1] = 1'b0;

    // line 2: inverse of line 1, or product-term clock when permitted
    if (l3_use_pt) begin
      lvl[2] = pterm[cfg_q.l3_pt_sel];
      en[2]  = 1'b1;
    end else begin
      lvl[2] = ~l2_lvl;
      en[2]  = l2_en;
    end
    rise_en[2] = 1'b1;
    fall_en[2] = 1'b0;
  end

endmodule

// File: rtl/blkclk_edge_qual.sv
module blkclk_edge_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic lvl_in,
  input  logic en_in,
  input  logic rise_en,
  input  logic fall_en,
  output logic lvl_o,
  output logic evt_o
);

  logic       lvl_q,  lvl_d;
  logic       prev_q, prev_d;
  logic       en_q,   en_d;
  logic [1:0] arm_q,  arm_d;
  logic       evt_q,  evt_d;
  logic       rose;
  logic       fell;

  always_comb begin
    rose = lvl_q & ~prev_q;
    fell = ~lvl_q & prev_q;
    if (run) begin
      lvl_d  = lvl_in;
      prev_d = lvl_q;
      en_d   = en_in;
      arm_d  = {arm_q[0], 1'b1};
      evt_d  = arm_q[1] & en_q & ((rise_en & rose) | (fall_en & fell));
    end else begin
      lvl_d  = 1'b0;
      prev_d = 1'b0;
      en_d   = 1'b0;
      arm_d  = 2'b00;
      evt_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
      en_q   <= 1'b0;
      arm_q  <= 2'b00;
      evt_q  <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      prev_q <= prev_d;
      en_q   <= en_d;
      arm_q  <= arm_d;
      evt_q  <= evt_d;
    end
  end

  assign lvl_o = lvl_q;
  assign evt_o = evt_q;

endmodule

// File: rtl/blkclk_gen.sv
module blkclk_gen
  import blkclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       gclk,
  input  logic [3:0]       pterm,
  input  logic [13:0]      cfg_word,
  output logic [2:0]       line_clk,
  output logic [2:0]       line_evt,
  output logic             cfg_err
);

  logic             run;
  cfg_t             cfg_q;
  logic             l3_use_pt;
  logic [LINES-1:0] sel_lvl;
  logic [LINES-1:0] sel_en;
  logic [LINES-1:0] sel_rise;
  logic [LINES-1:0] sel_fall;

  blkclk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  blkclk_cfg_hold u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .cfg_in    (cfg_word),
    .cfg_q     (cfg_q),
    .l3_use_pt (l3_use_pt),
    .cfg_err   (cfg_err)
  );

  blkclk_src_sel u_sel (
    .cfg_q     (cfg_q),
    .l3_use_pt (l3_use_pt),
    .gclk      (gclk),
    .pterm     (pterm),
    .lvl       (sel_lvl),
    .en        (sel_en),
    .rise_en   (sel_rise),
    .fall_en   (sel_fall)
  );

  for (genvar li = 0; li < LINES; li++) begin : g_line
    blkclk_edge_qual u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .lvl_in  (sel_lvl[li]),
      .en_in   (sel_en[li]),
      .rise_en (sel_rise[li]),
      .fall_en (sel_fall[li]),
      .lvl_o   (line_clk[li]),
      .evt_o   (line_evt[li])
    );
  end

endmodule

// File: rtl/blkclk_chk.sv
module blkclk_chk
  import blkclk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input cfg_t       cfg_q,
  input logic       l3_use_pt,
  input logic [3:0] pterm,
  input logic [2:0] line_clk,
  input logic [2:0] line_evt,
  input logic       cfg_err
);

  // R1: captured configuration never moves once the block runs
  a_r1_cfg_static: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(cfg_q));

  // R3: rising-only mode pulses only after a high level was seen
  a_r3_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.l1_mode == EDGE_RISE && line_evt[0]) |-> $past(line_clk[0]));

  // R6: a line 0 pulse needs the enable term high two edges earlier
  a_r6_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt[0] |-> $past(pterm[cfg_q.l1_en_sel], 2));

  // R8: complement relation between lines 1 and 2
  a_r8_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !l3_use_pt) |-> (line_clk[2] != line_clk[1]));

  // R10: illegal mix is flagged
  a_r10_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && cfg_q.l2_en_use && cfg_q.l3_pt) |-> cfg_err);

  // R12: every pulse follows a change of the reported level
  a_r12_after_change: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt[1] |-> ($past(line_clk[1]) != $past(line_clk[1], 2)));

endmodule

bind blkclk_gen blkclk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .cfg_q     (cfg_q),
  .l3_use_pt (l3_use_pt),
  .pterm     (pterm),
  .line_clk  (line_clk),
  .line_evt  (line_evt),
  .cfg_err   (cfg_err)
);

// File: tb/blkclk_gen_test.sv
module blkclk_gen_test;

  logic        clk;
  logic        rst_n;
  logic [3:0]  gclk;
  logic [3:0]  pterm;
  logic [13:0] cfg_word;
  logic [2:0]  line_clk;
  logic [2:0]  line_evt;
  logic        cfg_err;

  int n_chk;
  int n_bad;
  int cnt0, cnt1, cnt2;
  bit done;

  blkclk_gen uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .gclk     (gclk),
    .pterm    (pterm),
    .cfg_word (cfg_word),
    .line_clk (line_clk),
    .line_evt (line_evt),
    .cfg_err  (cfg_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (line_evt[0] === 1'b1) cnt0++;
    if (line_evt[1] === 1'b1) cnt1++;
    if (line_evt[2] === 1'b1) cnt2++;
  end

  // word layout: [1:0] l0 src, [3:2] l0 mode, [5:4] l0 enable term,
  // [7:6] l1 src, [8] l1 enable use, [10:9] l1 enable term,
  // [11] l2 product-term clock, [13:12] l2 term
  function automatic logic [13:0] mk(logic [1:0] s0, logic [1:0] m0, logic [1:0] e0,
                                     logic [1:0] s1, logic u1, logic [1:0] e1,
                                     logic p2, logic [1:0] s2);
    return {s2, p2, e1, u1, s1, e0, m0, s0};
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(logic [13:0] w, logic [3:0] pt);
    rst_n    = 1'b0;
    gclk     = 4'h0;
    pterm    = pt;
    cfg_word = w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    cnt0 = 0; cnt1 = 0; cnt2 = 0;
  endtask

  task automatic tog_g(int idx, int n);
    for (int k = 0; k < n; k++) begin
      gclk[idx] = ~gclk[idx];
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic tog_p(int idx, int n);
    for (int k = 0; k < n; k++) begin
      pterm[idx] = ~pterm[idx];
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; gclk = 4'hF; pterm = 4'hF;
    cfg_word = mk(2'd0, 2'd3, 2'd0, 2'd0, 1'b1, 2'd0, 1'b1, 2'd0);
    repeat (3) @(negedge clk);
    check("R2 line_clk", int'(line_clk), 0);
    check("R2 line_evt", int'(line_evt), 0);
    check("R2 cfg_err", int'(cfg_err), 0);
  endtask

  task automatic t_rise;
    start(mk(2'd2, 2'd0, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0), 4'b0010);
    tog_g(2, 8);
    check("R3 rising pulses", cnt0, 4);
  endtask

  task automatic t_fall;
    start(mk(2'd2, 2'd1, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0), 4'b0010);
    tog_g(2, 8);
    check("R4 falling pulses", cnt0, 4);
  endtask

  task automatic t_both;
    start(mk(2'd3, 2'd2, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0), 4'b0001);
    tog_g(3, 8);
    check("R5 dual-edge pulses", cnt0, 8);
  endtask

  task automatic t_en_low;
    start(mk(2'd3, 2'd2, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0), 4'b1110);
    tog_g(3, 8);
    check("R6 enable low", cnt0, 0);
  endtask

  task automatic t_select;
    start(mk(2'd2, 2'd2, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0), 4'b0010);
    tog_g(0, 6); tog_g(1, 6); tog_g(3, 6);
    check("R13 unselected sources", cnt0, 0);
  endtask

  task automatic t_line1;
    start(mk(2'd0, 2'd0, 2'd0, 2'd1, 1'b1, 2'd2, 1'b0, 2'd0), 4'b0100);
    tog_g(1, 8);
    check("R7 enabled line 1", cnt1, 4);
    check("R8 inverse line 2 pulses", cnt2, 4);
    gclk[1] = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 inverse level", int'(line_clk[2:1]), 1);
    gclk[1] = 1'b0;
    repeat (4) @(negedge clk);
    cnt1 = 0; cnt2 = 0;
    pterm[2] = 1'b0;
    tog_g(1, 8);
    check("R7 enable low", cnt1, 0);
    check("R8 shared enable low", cnt2, 0);
    start(mk(2'd0, 2'd0, 2'd0, 2'd1, 1'b0, 2'd2, 1'b0, 2'd0), 4'b0000);
    tog_g(1, 8);
    check("R7 no enable used", cnt1, 4);
  endtask

  task automatic t_ptclk;
    start(mk(2'd0, 2'd0, 2'd0, 2'd1, 1'b0, 2'd0, 1'b1, 2'd3), 4'b0000);
    tog_p(3, 8);
    check("R9 product-term clock", cnt2, 4);
    cnt2 = 0;
    tog_g(1, 8);
    check("R9 global ignored", cnt2, 0);
    check("R9 line 1 still runs", cnt1, 4);
    check("R9 no error", int'(cfg_err), 0);
  endtask

  task automatic t_illegal;
    start(mk(2'd0, 2'd0, 2'd0, 2'd1, 1'b1, 2'd2, 1'b1, 2'd3), 4'b0100);
    check("R10 error flag", int'(cfg_err), 1);
    tog_p(3, 8);
    check("R10 term clock rejected", cnt2, 0);
    tog_g(1, 8);
    check("R10 fallback inverse", cnt2, 4);
  endtask

  task automatic t_rsvd;
    start(mk(2'd1, 2'd3, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0), 4'b0001);
    check("R11 error flag", int'(cfg_err), 1);
    tog_g(1, 8);
    check("R11 acts as rising", cnt0, 4);
  endtask

  task automatic t_static;
    start(mk(2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0), 4'b0001);
    cfg_word = mk(2'd0, 2'd2, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0);
    repeat (3) @(negedge clk);
    tog_g(0, 8);
    check("R1 running change ignored", cnt0, 4);
  endtask

  task automatic t_latency;
    start(mk(2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0), 4'b0001);
    gclk[0] = 1'b1;
    @(negedge clk);
    check("R12 level after first edge", int'(line_clk[0]), 1);
    check("R12 no pulse yet", int'(line_evt[0]), 0);
    @(negedge clk);
    check("R12 pulse after second edge", int'(line_evt[0]), 1);
    @(negedge clk);
    check("R12 pulse one cycle", int'(line_evt[0]), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    cnt0 = 0; cnt1 = 0; cnt2 = 0;
    t_reset;
    t_rise;
    t_fall;
    t_both;
    t_en_low;
    t_select;
    t_line1;
    t_ptclk;
    t_illegal;
    t_rsvd;
    t_static;
    t_latency;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule